// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access may proceed once a page table entry has been found for it. It takes the entry's protection fields and class key, the segment's two key bits, the privilege state and the access kind (fetch, load or store). It also takes two 64-bit per-class mask registers: a data authority mask and an instruction authority mask. From these it returns the read/write/execute set the access may use, a grant or deny verdict, a set of fault-cause bits, and requests to write back the entry's referenced and changed bits.

Three independent sources of permission are ANDed together:
- a 3-bit protection code, interpreted under the effective key;
- the entry's no-execute and guarded bits;
- a 2-bit mask pair selected by the entry's class key.

Fetch faults and data faults report their causes on separate bit groups. A request is presented with `req_valid`. The result appears one clock later with `rsp_valid`. Page table search, address formation and interrupt delivery belong to neighbouring blocks.

Top module: `page_perm_eval`

## Requirements
- R1: The effective key is `seg_key_user` when `req_user` is 1, and `seg_key_sup` otherwise.
- R2: The protection code is `{pte_pp_hi, pte_pp}`. Under key 0, codes 0, 1 and 2 give read/write/execute, codes 3 and 6 give read/execute, and codes 4, 5 and 7 give nothing. `rsp_perm` bit 2 is read, bit 1 is write and bit 0 is execute.
- R3: Under key 1, codes 2 gives read/write/execute, codes 1 and 3 give read/execute, and codes 0, 4, 5, 6 and 7 give nothing.
- R4: When `pte_noexec` or `pte_guard` is set, execute is removed and read and write are left untouched.
- R5: When `amask_en` is 1, the bit pair of `amask` at bit 2*(31-`pte_class`) is taken (default 5-bit class). Its upper bit removes write and its lower bit removes read. When `amask_en` is 0, neither mask has any effect.
- R6: When `amask_en` and `imask_en` are both 1, bit 2*(31-`pte_class`) of `imask` removes execute. When `imask_en` is 0, `imask` has no effect.
- R7: `req_access` is encoded as fetch=0, load=1, store=2, with 3 handled as a load. A fetch needs execute, a load needs read and a store needs write. `rsp_grant` is 1 only when every source permits the needed right.
- R8: A denied fetch sets `flt_noexec` if the no-execute/guarded source denied execute. Otherwise it sets `flt_prot` if the protection code denied execute. Independently, it sets `flt_imask` if the instruction mask denied execute.
- R9: A denied data access sets `flt_prot` if the protection code denied the needed right, `flt_store` if it is a store, and `flt_amask` if the authority mask denied the right. A grant sets no fault bit.
- R10: A grant with `pte_ref` clear raises `rsp_set_ref`. A deny never raises it.
- R11: A grant with `pte_chg` clear behaves by access kind. For a store it raises `rsp_set_chg`. For any other access it clears write in `rsp_perm`. A deny reports the combined permission set unchanged.
- R12: Every output is registered with one cycle of latency. `rsp_valid` follows `req_valid`. After reset, and in any cycle without a request, all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_access | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_user | input | 1 | 1 = problem (user) state |
| seg_key_sup | input | 1 | Segment key for supervisor state |
| seg_key_user | input | 1 | Segment key for user state |
| pte_pp_hi | input | 1 | High protection bit of the entry |
| pte_pp | input | 2 | Low protection field of the entry |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_class | input | 5 | Entry class key |
| pte_ref | input | 1 | Entry referenced bit |
| pte_chg | input | 1 | Entry changed bit |
| amask | input | 64 | Data authority mask, two bits per class |
| imask | input | 64 | Instruction authority mask, two bits per class |
| amask_en | input | 1 | Class-mask protection enabled |
| imask_en | input | 1 | Instruction mask check present |
| rsp_valid | output | 1 | Result valid |
| rsp_grant | output | 1 | Access granted |
| rsp_perm | output | 3 | Permitted set {read, write, execute} |
| flt_noexec | output | 1 | Fetch denied by no-execute/guarded |
| flt_prot | output | 1 | Denied by protection code |
| flt_imask | output | 1 | Fetch denied by instruction mask |
| flt_store | output | 1 | Denied access was a store |
| flt_amask | output | 1 | Data access denied by authority mask |
| rsp_set_ref | output | 1 | Write back referenced bit |
| rsp_set_chg | output | 1 | Write back changed bit |

## Verification
The bench drives fetches that are denied by more than one source at once. A design that reports the protection cause alongside the no-execute cause, or drops the instruction-mask cause, shows up there. The mask position is probed at class 3 and class 31. A design that indexes the pair from the low end, or swaps the read and write bits, denies the wrong access. Disabling each mask with its bits set exposes a design that ignores the enables. Non-store grants with the changed bit clear catch a design that still returns write, and denied accesses with the referenced bit clear catch spurious write-back requests.

// File: rtl/perm_eval_pkg.sv
package perm_eval_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } access_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic noexec;
        logic prot;
        logic imask;
        logic store;
        logic amask;
    } fault_t;

    localparam perm_t PERM_NONE = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
    localparam perm_t PERM_RX   = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
    localparam perm_t PERM_RWX  = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};

    function automatic perm_t need_of(input access_e acc);
        perm_t n;
        n = PERM_NONE;
        case (acc)
            ACC_FETCH: n.ex = 1'b1;
            ACC_STORE: n.wr = 1'b1;
            default:   n.rd = 1'b1;
        endcase
        return n;
    endfunction

    function automatic perm_t perm_and(input perm_t a, input perm_t b);
        return '{rd: a.rd & b.rd, wr: a.wr & b.wr, ex: a.ex & b.ex};
    endfunction

    function automatic logic lacks(input perm_t need, input perm_t have);
        return (need.rd & ~have.rd) | (need.wr & ~have.wr) | (need.ex & ~have.ex);
    endfunction

endpackage

// File: rtl/ppcode_decode.sv
module ppcode_decode
    import perm_eval_pkg::*;
(
    input  logic       key,
    input  logic [2:0] code,
    output perm_t      perm
);

    always_comb begin
        perm = PERM_NONE;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: perm = PERM_RWX;
                3'd3, 3'd6:       perm = PERM_RX;
                default:          perm = PERM_NONE;
            endcase
        end else begin
            case (code)
                3'd2:       perm = PERM_RWX;
                3'd1, 3'd3: perm = PERM_RX;
                default:    perm = PERM_NONE;
            endcase
        end
    end

endmodule

// File: rtl/class_mask_decode.sv
module class_mask_decode
    import perm_eval_pkg::*;
#(
    parameter int KEY_W = 5
) (
    input  logic [KEY_W-1:0]        cls,
    input  logic [2*(2**KEY_W)-1:0] amask,
    input  logic [2*(2**KEY_W)-1:0] imask,
    input  logic                    amask_en,
    input  logic                    imask_en,
    output perm_t                   perm
);

    localparam int CLASSES = 2 ** KEY_W;
    localparam int MASK_W  = 2 * CLASSES;

    // Class k owns the pair starting at bit 2*(CLASSES-1-k): class 0 sits at the top.
    logic [1:0] a_pair [CLASSES];
    logic       i_bit  [CLASSES];

    for (genvar k = 0; k < CLASSES; k++) begin : g_cls
        localparam int LO = 2 * (CLASSES - 1 - k);
        assign a_pair[k] = amask[LO+1:LO];
        assign i_bit[k]  = imask[LO];
    end

    logic [1:0] a_sel;
    logic       i_sel;
    assign a_sel = a_pair[cls];
    assign i_sel = i_bit[cls];

    always_comb begin
        perm = PERM_RWX;
        if (amask_en) begin
            perm.wr = ~a_sel[1];
            perm.rd = ~a_sel[0];
            perm.ex = ~(imask_en & i_sel);
        end
    end

    logic unused_w;
    assign unused_w = ^{MASK_W[0]};

endmodule

// File: rtl/access_judge.sv
module access_judge
    import perm_eval_pkg::*;
(
    input  access_e acc,
    input  perm_t   pp_perm,
    input  perm_t   nx_perm,
    input  perm_t   cls_perm,
    input  logic    pte_ref,
    input  logic    pte_chg,
    output logic    grant,
    output perm_t   perm,
    output fault_t  fault,
    output logic    set_ref,
    output logic    set_chg
);

    perm_t need;
    perm_t combined;
    logic  deny;
    logic  is_fetch;
    logic  is_store;

    assign need     = need_of(acc);
    assign combined = perm_and(perm_and(nx_perm, pp_perm), cls_perm);
    assign deny     = lacks(need, combined);
    assign is_fetch = (acc == ACC_FETCH);
    assign is_store = (acc == ACC_STORE);
    assign grant    = ~deny;

    always_comb begin
        fault = '0;
        if (deny) begin
            if (is_fetch) begin
                if (!nx_perm.ex)       fault.noexec = 1'b1;
                else if (!pp_perm.ex)  fault.prot   = 1'b1;
                fault.imask = ~cls_perm.ex;
            end else begin
                fault.prot  = lacks(need, pp_perm);
                fault.store = is_store;
                fault.amask = lacks(need, cls_perm);
            end
        end
    end

    always_comb begin
        perm    = combined;
        set_ref = 1'b0;
        set_chg = 1'b0;
        if (!deny) begin
            set_ref = ~pte_ref;
            if (!pte_chg) begin
                if (is_store) set_chg = 1'b1;
                else          perm.wr = 1'b0;
            end
        end
    end

endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
    import perm_eval_pkg::*;
#(
    parameter int KEY_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_access,
    input  logic                    req_user,
    input  logic                    seg_key_sup,
    input  logic                    seg_key_user,
    input  logic                    pte_pp_hi,
    input  logic [1:0]              pte_pp,
    input  logic                    pte_noexec,
    input  logic                    pte_guard,
    input  logic [KEY_W-1:0]        pte_class,
    input  logic                    pte_ref,
    input  logic                    pte_chg,
    input  logic [2*(2**KEY_W)-1:0] amask,
    input  logic [2*(2**KEY_W)-1:0] imask,
    input  logic                    amask_en,
    input  logic                    imask_en,
    output logic                    rsp_valid,
    output logic                    rsp_grant,
    output logic [2:0]              rsp_perm,
    output logic                    flt_noexec,
    output logic                    flt_prot,
    output logic                    flt_imask,
    output logic                    flt_store,
    output logic                    flt_amask,
    output logic                    rsp_set_ref,
    output logic                    rsp_set_chg
);

    access_e acc;
    logic    eff_key;
    perm_t   pp_perm, nx_perm, cls_perm, perm_c;
    fault_t  fault_c;
    logic    grant_c, set_ref_c, set_chg_c;

    assign acc     = access_e'(req_access);
    assign eff_key = req_user ? seg_key_user : seg_key_sup;

    always_comb begin
        nx_perm = PERM_RWX;
        if (pte_noexec || pte_guard) nx_perm.ex = 1'b0;
    end

    ppcode_decode u_pp (
        .key  (eff_key),
        .code ({pte_pp_hi, pte_pp}),
        .perm (pp_perm)
    );

    class_mask_decode #(.KEY_W(KEY_W)) u_cls (
        .cls      (pte_class),
        .amask    (amask),
        .imask    (imask),
        .amask_en (amask_en),
        .imask_en (imask_en),
        .perm     (cls_perm)
    );

    access_judge u_judge (
        .acc      (acc),
        .pp_perm  (pp_perm),
        .nx_perm  (nx_perm),
        .cls_perm (cls_perm),
        .pte_ref  (pte_ref),
        .pte_chg  (pte_chg),
        .grant    (grant_c),
        .perm     (perm_c),
        .fault    (fault_c),
        .set_ref  (set_ref_c),
        .set_chg  (set_chg_c)
    );

    fault_t fault_q;
    perm_t  perm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_grant   <= 1'b0;
            perm_q      <= PERM_NONE;
            fault_q     <= '0;
            rsp_set_ref <= 1'b0;
            rsp_set_chg <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_grant   <= grant_c;
                perm_q      <= perm_c;
                fault_q     <= fault_c;
                rsp_set_ref <= set_ref_c;
                rsp_set_chg <= set_chg_c;
            end else begin
                rsp_grant   <= 1'b0;
                perm_q      <= PERM_NONE;
                fault_q     <= '0;
                rsp_set_ref <= 1'b0;
                rsp_set_chg <= 1'b0;
            end
        end
    end

    assign rsp_perm   = perm_q;
    assign flt_noexec = fault_q.noexec;
    assign flt_prot   = fault_q.prot;
    assign flt_imask  = fault_q.imask;
    assign flt_store  = fault_q.store;
    assign flt_amask  = fault_q.amask;

    // R12: result strobe trails the request by one cycle
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_grant && rsp_perm == 3'b000 && !rsp_set_ref && !rsp_set_chg
                        && !flt_noexec && !flt_prot && !flt_imask && !flt_store && !flt_amask));
    // R9: a grant carries no fault cause
    a_r9_grant_no_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_grant |-> !(flt_noexec || flt_prot || flt_imask || flt_store || flt_amask));
    // R8: no-execute and protection causes are never reported together
    a_r8_cause_priority: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flt_noexec, flt_prot}) || !flt_noexec);
    // R10: referenced write-back only on a grant
    a_r10_ref_on_grant: assert property (@(posedge clk) disable iff (rst)
        rsp_set_ref |-> rsp_grant);
    // R11: changed write-back only for a granted store
    a_r11_chg_store_only: assert property (@(posedge clk) disable iff (rst)
        rsp_set_chg |-> (rsp_grant && $past(req_access) == 2'd2));
    // R7: a granted fetch always carries execute
    a_r7_fetch_has_exec: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant && $past(req_access) == 2'd0) |-> rsp_perm[0]);
    // R9: store flag appears only for a denied store
    a_r9_store_flag: assert property (@(posedge clk) disable iff (rst)
        flt_store |-> (!rsp_grant && $past(req_access) == 2'd2));

endmodule

// File: tb/tb_page_perm_eval.sv
module tb_page_perm_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_access = 2'd0;
    logic        req_user = 1'b0, seg_key_sup = 1'b0, seg_key_user = 1'b0;
    logic        pte_pp_hi = 1'b0;
    logic [1:0]  pte_pp = 2'd0;
    logic        pte_noexec = 1'b0, pte_guard = 1'b0;
    logic [4:0]  pte_class = 5'd0;
    logic        pte_ref = 1'b1, pte_chg = 1'b1;
    logic [63:0] amask = '0, imask = '0;
    logic        amask_en = 1'b0, imask_en = 1'b0;
    logic        rsp_valid, rsp_grant;
    logic [2:0]  rsp_perm;
    logic        flt_noexec, flt_prot, flt_imask, flt_store, flt_amask;
    logic        rsp_set_ref, rsp_set_chg;

    always #2 clk = ~clk;

    page_perm_eval dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_access(req_access),
        .req_user(req_user), .seg_key_sup(seg_key_sup), .seg_key_user(seg_key_user),
        .pte_pp_hi(pte_pp_hi), .pte_pp(pte_pp), .pte_noexec(pte_noexec),
        .pte_guard(pte_guard), .pte_class(pte_class), .pte_ref(pte_ref),
        .pte_chg(pte_chg), .amask(amask), .imask(imask), .amask_en(amask_en),
        .imask_en(imask_en), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_perm(rsp_perm), .flt_noexec(flt_noexec), .flt_prot(flt_prot),
        .flt_imask(flt_imask), .flt_store(flt_store), .flt_amask(flt_amask),
        .rsp_set_ref(rsp_set_ref), .rsp_set_chg(rsp_set_chg)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    pending = 1'b0;
    string exp_tag;
    logic [11:0] exp_vec;

    // bundle: valid, grant, perm[2:0], noexec, prot, imask, store, amask, ref, chg
    function automatic logic [11:0] act_vec();
        return {rsp_valid, rsp_grant, rsp_perm, flt_noexec, flt_prot, flt_imask,
                flt_store, flt_amask, rsp_set_ref, rsp_set_chg};
    endfunction

    task automatic check(string tag, logic [11:0] a, logic [11:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s: actual=%03h expected=%03h", tag, a, e);
        end
    endtask

    // Behavioural reference: integer arithmetic on the current inputs.
    function automatic logic [11:0] model();
        int key, code, need, have_pp, have_nx, have_cm, have, pos;
        int g, nxf, prf, imf, stf, amf, rf, cf;
        if (!req_valid) return 12'h000;
        key  = req_user ? int'(seg_key_user) : int'(seg_key_sup);
        code = int'(pte_pp_hi) * 4 + int'(pte_pp);
        // permission sets as integers: 4 read, 2 write, 1 execute
        if (key == 0)
            have_pp = (code <= 2) ? 7 : ((code == 3 || code == 6) ? 5 : 0);
        else
            have_pp = (code == 2) ? 7 : ((code == 1 || code == 3) ? 5 : 0);
        have_nx = (pte_noexec || pte_guard) ? 6 : 7;
        have_cm = 7;
        if (amask_en) begin
            pos = 2 * (31 - int'(pte_class));
            if (amask[pos+1]) have_cm -= 2;
            if (amask[pos])   have_cm -= 4;
            if (imask_en && imask[pos]) have_cm -= 1;
        end
        have = have_pp & have_nx & have_cm;
        need = (req_access == 2'd0) ? 1 : ((req_access == 2'd2) ? 2 : 4);
        g = ((need & have) != 0) ? 1 : 0;
        nxf = 0; prf = 0; imf = 0; stf = 0; amf = 0; rf = 0; cf = 0;
        if (g == 0) begin
            if (req_access == 2'd0) begin
                if ((have_nx & 1) == 0) nxf = 1;
                else if ((have_pp & 1) == 0) prf = 1;
                if ((have_cm & 1) == 0) imf = 1;
            end else begin
                if ((need & have_pp) == 0) prf = 1;
                if (req_access == 2'd2) stf = 1;
                if ((need & have_cm) == 0) amf = 1;
            end
        end else begin
            if (!pte_ref) rf = 1;
            if (!pte_chg) begin
                if (req_access == 2'd2) cf = 1;
                else if ((have & 2) != 0) have -= 2;
            end
        end
        return {1'b1, g[0], have[2:0], nxf[0], prf[0], imf[0], stf[0], amf[0], rf[0], cf[0]};
    endfunction

    // One cycle: check the previous request's result, then present a new one.
    task automatic step(string tag);
        @(negedge clk);
        if (pending) check(exp_tag, act_vec(), exp_vec);
        exp_tag = tag;
    endtask

    task automatic fin();
        exp_vec = model();
        pending = 1'b1;
    endtask

    task automatic base();
        req_valid = 1'b1; req_access = 2'd1; req_user = 1'b0;
        seg_key_sup = 1'b0; seg_key_user = 1'b0; pte_pp_hi = 1'b0; pte_pp = 2'd2;
        pte_noexec = 1'b0; pte_guard = 1'b0; pte_class = 5'd0;
        pte_ref = 1'b1; pte_chg = 1'b1; amask = '0; imask = '0;
        amask_en = 1'b0; imask_en = 1'b0;
    endtask

    task automatic req(string tag, int acc, int code, bit key);
        step(tag);
        base();
        req_access = acc[1:0];
        {pte_pp_hi, pte_pp} = code[2:0];
        seg_key_sup = key;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R12 reset state", act_vec(), 12'h000);

        // R1: key choice by privilege
        step("R1 user key 1");
        base(); req_user = 1'b1; seg_key_user = 1'b1; pte_pp = 2'd0; fin();
        step("R1 supervisor key 0");
        base(); req_user = 1'b0; seg_key_user = 1'b1; pte_pp = 2'd0; fin();

        // R2: key 0 table
        req("R2 key0 code3 store", 2, 3, 1'b0); fin();
        req("R2 key0 code6 fetch", 0, 6, 1'b0); fin();
        req("R2 key0 code5 load", 1, 5, 1'b0); fin();
        req("R2 key0 code4 load", 1, 4, 1'b0); fin();
        req("R2 key0 code2 store", 2, 2, 1'b0); fin();
        req("R2 key0 code1 store", 2, 1, 1'b0); fin();

        // R3: key 1 table
        req("R3 key1 code2 store", 2, 2, 1'b1); fin();
        req("R3 key1 code1 store", 2, 1, 1'b1); fin();
        req("R3 key1 code3 fetch", 0, 3, 1'b1); fin();
        req("R3 key1 code6 load", 1, 6, 1'b1); fin();
        req("R3 key1 code0 load", 1, 0, 1'b1); fin();

        // R4: no-execute / guarded
        req("R4 noexec fetch", 0, 2, 1'b0); pte_noexec = 1'b1; fin();
        req("R4 guard store", 2, 2, 1'b0); pte_guard = 1'b1; fin();
        req("R4 guard fetch", 0, 2, 1'b0); pte_guard = 1'b1; fin();

        // R5: authority mask position and enable
        req("R5 class3 write bit store", 2, 2, 1'b0);
        amask_en = 1'b1; pte_class = 5'd3; amask[57] = 1'b1; fin();
        req("R5 class3 write bit load", 1, 2, 1'b0);
        amask_en = 1'b1; pte_class = 5'd3; amask[57] = 1'b1; fin();
        req("R5 class3 read bit load", 1, 2, 1'b0);
        amask_en = 1'b1; pte_class = 5'd3; amask[56] = 1'b1; fin();
        req("R5 class31 read bit load", 1, 2, 1'b0);
        amask_en = 1'b1; pte_class = 5'd31; amask[0] = 1'b1; fin();
        req("R5 neighbour class unaffected", 1, 2, 1'b0);
        amask_en = 1'b1; pte_class = 5'd30; amask[0] = 1'b1; fin();
        req("R5 mask disabled", 2, 2, 1'b0);
        amask_en = 1'b0; amask = '1; imask = '1; fin();

        // R6: instruction mask
        req("R6 imask fetch", 0, 2, 1'b0);
        amask_en = 1'b1; imask_en = 1'b1; pte_class = 5'd7; imask[48] = 1'b1; fin();
        req("R6 imask absent", 0, 2, 1'b0);
        amask_en = 1'b1; imask_en = 1'b0; pte_class = 5'd7; imask[48] = 1'b1; fin();
        req("R6 imask load unaffected", 1, 2, 1'b0);
        amask_en = 1'b1; imask_en = 1'b1; pte_class = 5'd7; imask[48] = 1'b1; fin();

        // R7: access kinds, code 3 as load
        req("R7 alt access as load", 3, 3, 1'b0); fin();
        req("R7 store on read/execute", 2, 3, 1'b0); fin();

        // R8: fetch cause priority
        req("R8 noexec over prot", 0, 0, 1'b1);
        pte_noexec = 1'b1; amask_en = 1'b1; imask_en = 1'b1; imask[62] = 1'b1; fin();
        req("R8 prot cause", 0, 0, 1'b1); fin();

        // R9: data causes
        req("R9 store prot+amask", 2, 3, 1'b0);
        amask_en = 1'b1; amask[63] = 1'b1; fin();
        req("R9 load amask only", 1, 2, 1'b0);
        amask_en = 1'b1; amask[62] = 1'b1; fin();

        // R10: referenced
        req("R10 ref clear grant", 1, 2, 1'b0); pte_ref = 1'b0; fin();
        req("R10 ref clear deny", 1, 5, 1'b0); pte_ref = 1'b0; fin();

        // R11: changed
        req("R11 load chg clear", 1, 2, 1'b0); pte_chg = 1'b0; fin();
        req("R11 store chg clear", 2, 2, 1'b0); pte_chg = 1'b0; fin();
        req("R11 fetch chg clear ref clear", 0, 0, 1'b0); pte_chg = 1'b0; pte_ref = 1'b0; fin();
        req("R11 deny keeps set", 1, 5, 1'b0); pte_chg = 1'b0; fin();

        // R12: idle cycle
        step("R12 idle");
        base(); req_valid = 1'b0; fin();

        for (int i = 0; i < 3000; i++) begin
            step("random R7 R8 R9");
            req_valid    = ($urandom_range(0, 7) != 0);
            req_access   = 2'($urandom_range(0, 3));
            req_user     = 1'($urandom);
            seg_key_sup  = 1'($urandom);
            seg_key_user = 1'($urandom);
            {pte_pp_hi, pte_pp} = 3'($urandom);
            pte_noexec   = ($urandom_range(0, 3) == 0);
            pte_guard    = ($urandom_range(0, 3) == 0);
            pte_class    = 5'($urandom);
            pte_ref      = 1'($urandom);
            pte_chg      = 1'($urandom);
            amask        = {$urandom, $urandom} & {$urandom, $urandom};
            imask        = {$urandom, $urandom} & {$urandom, $urandom};
            amask_en     = 1'($urandom);
            imask_en     = 1'($urandom);
            fin();
        end

        step("drain");
        base(); req_valid = 1'b0; pending = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule